// File: doc/BRIEF.md
# L2 Lookup Table Access Engine

This block is the register-file front end of a switch's layer-2 lookup table. Host software fills a bank of ten 16-bit write-data registers with an entry, optionally sets an access address, and then writes a control word. Writing the control word starts an operation. The engine then runs a write, a direct read or a search against an internal table that holds `DEPTH` entries. It holds a busy flag for the whole operation. When the operation ends, it reports a hit flag and the matched index in a status register and places the result entry in a bank of ten read-data registers.

Entries are placed by a hash of their key. The key is the 48-bit MAC address together with a 12-bit forwarding ID. Entries can be found in six ways:

- by key match;
- by direct index;
- as the next valid entry after an address;
- as the next unicast entry;
- as the next multicast entry;
- as the next unicast entry learned on a given port.

The next-entry searches scan the table one entry per cycle. They wrap once around the table and report a miss if nothing qualifies.

Top module: `ltab_access`

## Requirements
- R1: After reset the status register, the access address register and every read-data register read as zero.
- R2: Register offsets are: control 0x0500 (write-only, reads zero), access address 0x0501 (13-bit index in bits 12:0, upper bits read zero), status 0x0502, write-data words 0x0510..0x0519, read-data words 0x0520..0x0529. Control fields are: table select bits 2:0 (the L2 table is code 4), operation bit 3 (1 = write, 0 = read), read method bits 6:4, port bits 11:8.
- R3: A control write while idle sets busy (status bit 13) from the next cycle until the operation ends. Writes, direct reads and key-match operations take one busy cycle. While busy, every host write (control, address or data) is ignored.
- R4: The status register packs the index as follows: bits 10:0 hold index bits 10:0, bit 14 holds index bit 11 and bit 11 holds index bit 12 (the L3 type flag, always 0 for this table). Bit 12 is hit. On a miss all index fields are zero.
- R5: The entry layout is: MAC in bits 47:0, forwarding ID in bits 59:48 (key = bits 59:0), multicast flag in bit 40, valid in bit 64, source port in bits 68:65. An L2 write ignores the address register and targets the slot given by XOR-folding the key in 6-bit chunks (for depth 64). The write is placed, with hit set and the slot index reported, when the slot is empty or already holds the same key. Otherwise it misses and the table is unchanged.
- R6: Only the 4 least significant bits of the tenth data word are stored, and read-data word 9 returns its upper 12 bits as zero.
- R7: Read method 0 (key match) ignores the address register, probes the hashed slot of the key in the write-data bank, and hits when that slot is valid and holds the same key.
- R8: Read method 1 (direct) reads the slot named by the address register and hits when the address is below the depth and the slot is valid.
- R9: Read method 2 (next valid) examines the slots starting one after the address, wrapping, with the address itself last. It reports the first valid slot, or a miss after all `DEPTH` slots, which takes `DEPTH` busy cycles.
- R10: Read method 3 finds the next valid entry with bit 40 clear (unicast). Read method 4 finds the next valid entry with bit 40 set (multicast). Both use the same scan order as R9.
- R11: Read method 5 finds the next valid unicast entry whose port field equals control bits 11:8.
- R12: On a read that hits, the read-data bank loads the found entry. On a read that misses, the read-data bank is cleared. A write leaves the read-data bank unchanged.
- R13: A command naming a table other than code 4, or a read method of 6 or 7, completes with a miss and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_waddr | input | 16 | Host write register offset |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 16 | Host read register offset |
| host_rdata | output | 16 | Read data for `host_raddr`, same cycle |

## Verification
The bench keeps its own model of which slots hold which keys, flags and ports, and predicts every hit and index from it. It targets three groups of corner cases.

- Hash collisions against a different key. A design that overwrote the slot would destroy the resident entry.
- Same-key rewrites. A design that refused them could not update an entry.
- Next-entry scans. These start at the last slot and at occupied slots, so that the wrap and the "address itself examined last" rule are exercised. An off-by-one scan would return the starting entry too early or miss it entirely.

Writes issued during a full-length empty scan must leave both the table and the address register untouched, which catches a design that lets a second command or new data slip in mid-operation. Unknown tables and methods, out-of-range direct indexes and the masked upper bits of the tenth word are checked through the status and read-data registers.

// File: rtl/ltab_pkg.sv
package ltab_pkg;

    localparam int HW        = 16;
    localparam int WORDS     = 10;
    localparam int TAIL_BITS = 4;
    localparam int ENTRY_W   = (WORDS - 1) * HW + TAIL_BITS;
    localparam int ADDR_W    = 13;

    localparam int KEY_W   = 60;
    localparam int MC_BIT  = 40;
    localparam int VLD_BIT = 64;
    localparam int PORT_LO = 65;
    localparam int PORT_W  = 4;

    localparam logic [15:0] REG_CTRL  = 16'h0500;
    localparam logic [15:0] REG_ADDR  = 16'h0501;
    localparam logic [15:0] REG_STAT  = 16'h0502;
    localparam logic [15:0] REG_WBANK = 16'h0510;
    localparam logic [15:0] REG_RBANK = 16'h0520;

    localparam logic [2:0] TBL_L2 = 3'd4;

    localparam logic [2:0] SRCH_KEY          = 3'd0;
    localparam logic [2:0] SRCH_INDEX        = 3'd1;
    localparam logic [2:0] SRCH_NEXT         = 3'd2;
    localparam logic [2:0] SRCH_NEXT_UC      = 3'd3;
    localparam logic [2:0] SRCH_NEXT_MC      = 3'd4;
    localparam logic [2:0] SRCH_NEXT_UC_PORT = 3'd5;

    // Control word, bits 11:0
    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              rsvd;
        logic [2:0]        method;
        logic              wr;
        logic [2:0]        tbl;
    } ctrl_t;

    // Status word layout
    typedef struct packed {
        logic        zero;
        logic        idx_ext;
        logic        busy;
        logic        hit;
        logic        is_l3;
        logic [10:0] idx_lo;
    } status_t;

    function automatic logic [KEY_W-1:0] entry_key(input logic [ENTRY_W-1:0] e);
        return e[KEY_W-1:0];
    endfunction

endpackage

// File: rtl/ltab_key_hash.sv
module ltab_key_hash #(
    parameter int KEY_BITS = 60,
    parameter int IW       = 6
) (
    input  logic [KEY_BITS-1:0] key,
    output logic [IW-1:0]       slot
);
    // XOR fold: key bit b lands on slot bit (b mod IW)
    always_comb begin
        slot = '0;
        for (int b = 0; b < KEY_BITS; b++) begin
            slot[b % IW] = slot[b % IW] ^ key[b];
        end
    end
endmodule

// File: rtl/ltab_host_regs.sv
module ltab_host_regs
    import ltab_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [HW-1:0]      wr_data,
    input  logic [15:0]        rd_addr,
    output logic [HW-1:0]      rd_data,
    input  logic               busy,
    input  logic               hit,
    input  logic [ADDR_W-1:0]  idx,
    input  logic [ENTRY_W-1:0] rentry,
    output logic               start,
    output ctrl_t              cmd,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [ENTRY_W-1:0] wentry
);
    logic [HW-1:0]        wbank [WORDS-1];
    logic [TAIL_BITS-1:0] wtail;
    logic                 wr_ok;
    status_t              stat;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (wr_addr == REG_CTRL);
    assign cmd   = ctrl_t'(wr_data[11:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wtail  <= '0;
            for (int w = 0; w < WORDS - 1; w++) wbank[w] <= '0;
        end else if (wr_ok) begin
            if (wr_addr == REG_ADDR) addr_q <= wr_data[ADDR_W-1:0];
            for (int w = 0; w < WORDS - 1; w++) begin
                if (wr_addr == REG_WBANK + 16'(w)) wbank[w] <= wr_data;
            end
            if (wr_addr == REG_WBANK + 16'(WORDS - 1)) wtail <= wr_data[TAIL_BITS-1:0];
        end
    end

    for (genvar g = 0; g < WORDS - 1; g++) begin : g_pack
        assign wentry[g*HW +: HW] = wbank[g];
    end
    assign wentry[ENTRY_W-1 -: TAIL_BITS] = wtail;

    always_comb begin
        stat         = '0;
        stat.idx_lo  = idx[10:0];
        stat.is_l3   = idx[12];
        stat.hit     = hit;
        stat.busy    = busy;
        stat.idx_ext = idx[11];
        rd_data      = '0;
        if (rd_addr == REG_ADDR) rd_data = HW'(addr_q);
        if (rd_addr == REG_STAT) rd_data = stat;
        for (int w = 0; w < WORDS - 1; w++) begin
            if (rd_addr == REG_RBANK + 16'(w)) rd_data = rentry[w*HW +: HW];
        end
        if (rd_addr == REG_RBANK + 16'(WORDS - 1)) rd_data = HW'(rentry[ENTRY_W-1 -: TAIL_BITS]);
    end

    // R6: tenth read word never shows bits above the stored nibble
    p_tail_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == REG_RBANK + 16'(WORDS - 1)) |-> (rd_data[HW-1:TAIL_BITS] == '0));

    // R2: address register never holds bits above the index width
    p_addr_width_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == REG_ADDR) |-> (rd_data[HW-1:ADDR_W] == '0));
endmodule

// File: rtl/ltab_engine.sv
module ltab_engine
    import ltab_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  ctrl_t              cmd,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [ENTRY_W-1:0] wentry,
    input  logic [IW-1:0]      key_slot,
    output logic               busy,
    output logic               hit,
    output logic [ADDR_W-1:0]  idx,
    output logic [ENTRY_W-1:0] rentry
);
    localparam logic [IW:0] LAST_STEP = (IW + 1)'(DEPTH - 1);

    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    state_e             st;
    ctrl_t              cmd_q;
    logic [IW-1:0]      ptr;
    logic [IW:0]        seen;
    logic               in_range;
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]   vld;

    logic [ENTRY_W-1:0] cur;
    logic               cur_vld, cur_uc, same_key;
    logic               scan, found, last, finish, do_store;

    assign cur      = mem[ptr];
    assign cur_vld  = vld[ptr];
    assign cur_uc   = !cur[MC_BIT];
    assign same_key = entry_key(cur) == entry_key(wentry);
    assign busy     = (st == ST_RUN);

    always_comb begin
        scan  = 1'b0;
        found = 1'b0;
        if (cmd_q.tbl == TBL_L2) begin
            if (cmd_q.wr) begin
                found = !cur_vld || same_key;
            end else begin
                case (cmd_q.method)
                    SRCH_KEY:          found = cur_vld && same_key;
                    SRCH_INDEX:        found = in_range && cur_vld;
                    SRCH_NEXT:         begin scan = 1'b1; found = cur_vld; end
                    SRCH_NEXT_UC:      begin scan = 1'b1; found = cur_vld && cur_uc; end
                    SRCH_NEXT_MC:      begin scan = 1'b1; found = cur_vld && !cur_uc; end
                    SRCH_NEXT_UC_PORT: begin
                        scan  = 1'b1;
                        found = cur_vld && cur_uc && (cur[PORT_LO +: PORT_W] == cmd_q.port);
                    end
                    default:           found = 1'b0;
                endcase
            end
        end
        last     = !scan || (seen == LAST_STEP);
        finish   = busy && (found || last);
        do_store = finish && found && cmd_q.wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cmd_q    <= '0;
            ptr      <= '0;
            seen     <= '0;
            in_range <= 1'b0;
            hit      <= 1'b0;
            idx      <= '0;
            rentry   <= '0;
            vld      <= '0;
        end else if (st == ST_IDLE) begin
            if (start) begin
                st       <= ST_RUN;
                cmd_q    <= cmd;
                seen     <= '0;
                hit      <= 1'b0;
                idx      <= '0;
                in_range <= start_addr < ADDR_W'(DEPTH);
                if (cmd.wr || cmd.method == SRCH_KEY) ptr <= key_slot;
                else if (cmd.method == SRCH_INDEX)    ptr <= start_addr[IW-1:0];
                else                                  ptr <= start_addr[IW-1:0] + 1'b1;
            end
        end else if (finish) begin
            st  <= ST_IDLE;
            hit <= found;
            idx <= found ? ADDR_W'(ptr) : '0;
            if (!cmd_q.wr) rentry <= found ? cur : '0;
            if (do_store) vld[ptr] <= wentry[VLD_BIT];
        end else begin
            ptr  <= ptr + 1'b1;
            seen <= seen + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_store) mem[ptr] <= wentry;
    end

    // R3: an accepted command raises busy on the next cycle
    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R3: the latched command stays put while the operation runs
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> (busy && $stable(cmd_q)));

    // R4: a miss reports no index
    p_miss_no_index_r4: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (idx == '0));

    // R8: a reported index is always inside the table
    p_index_in_table_r8: assert property (@(posedge clk) disable iff (rst)
        idx < ADDR_W'(DEPTH));

    // R9: a scan never examines more than DEPTH slots
    p_scan_bound_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (seen <= LAST_STEP));

    // R12: a read hit returns an entry that carries its valid bit
    p_read_hit_valid_r12: assert property (@(posedge clk) disable iff (rst)
        (finish && found && !cmd_q.wr) |=> rentry[VLD_BIT]);
endmodule

// File: rtl/ltab_access.sv
module ltab_access
    import ltab_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [15:0] host_waddr,
    input  logic [15:0] host_wdata,
    input  logic [15:0] host_raddr,
    output logic [15:0] host_rdata
);
    localparam int IW = $clog2(DEPTH);

    logic               start, busy, hit;
    ctrl_t              cmd;
    logic [ADDR_W-1:0]  addr_q, idx;
    logic [ENTRY_W-1:0] wentry, rentry;
    logic [IW-1:0]      key_slot;

    ltab_host_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(host_wr), .wr_addr(host_waddr), .wr_data(host_wdata),
        .rd_addr(host_raddr), .rd_data(host_rdata),
        .busy(busy), .hit(hit), .idx(idx), .rentry(rentry),
        .start(start), .cmd(cmd), .addr_q(addr_q), .wentry(wentry)
    );

    ltab_key_hash #(.KEY_BITS(KEY_W), .IW(IW)) u_hash (
        .key(entry_key(wentry)),
        .slot(key_slot)
    );

    ltab_engine #(.DEPTH(DEPTH), .IW(IW)) u_engine (
        .clk(clk), .rst(rst),
        .start(start), .cmd(cmd), .start_addr(addr_q),
        .wentry(wentry), .key_slot(key_slot),
        .busy(busy), .hit(hit), .idx(idx), .rentry(rentry)
    );
endmodule

// File: tb/ltab_access_bench.sv
`timescale 1ns/1ps
module ltab_access_bench;
    import ltab_pkg::*;

    localparam int DEPTH = 64;
    localparam int IW    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [15:0] host_waddr = '0, host_wdata = '0, host_raddr = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;

    bit               m_vld [DEPTH];
    bit [ENTRY_W-1:0] m_ent [DEPTH];

    ltab_access #(.DEPTH(DEPTH)) u_ltab_access (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [IW-1:0] fold(input logic [KEY_W-1:0] k);
        logic [IW-1:0] h = '0;
        for (int j = 0; j < KEY_W; j += IW) h ^= IW'(k >> j);
        return h;
    endfunction

    function automatic logic [ENTRY_W-1:0] mk(input logic [47:0] mac, input logic [11:0] fid,
                                             input logic [3:0] port, input logic [15:0] tag);
        logic [ENTRY_W-1:0] e = '0;
        e[47:0] = mac; e[59:48] = fid; e[VLD_BIT] = 1'b1; e[PORT_LO +: 4] = port;
        e[143:128] = tag; e[ENTRY_W-1 -: 4] = tag[3:0] ^ 4'h5;
        return e;
    endfunction

    task automatic load(input logic [ENTRY_W-1:0] e);
        for (int w = 0; w < WORDS - 1; w++) wr(REG_WBANK + 16'(w), e[w*HW +: HW]);
        wr(REG_WBANK + 16'(WORDS - 1), {12'hABC, e[ENTRY_W-1 -: 4]});
    endtask

    task automatic status(output bit h, output bit b, output int ix, output bit l3);
        logic [15:0] s;
        rd(REG_STAT, s);
        h = s[12]; b = s[13]; l3 = s[11];
        ix = int'(s[10:0]) | (int'(s[14]) << 11) | (int'(s[11]) << 12);
    endtask

    // Issues a control word and waits for busy to fall; returns busy cycles
    task automatic issue(input logic [15:0] c, output int cyc);
        bit h, b, l3; int ix;
        wr(REG_CTRL, c);
        cyc = 0;
        status(h, b, ix, l3);
        while (b && cyc < 1000) begin
            cyc++;
            @(negedge clk);
            status(h, b, ix, l3);
        end
    endtask

    function automatic logic [15:0] ctl(input logic [2:0] tbl, input bit w, input logic [2:0] m, input logic [3:0] p);
        return {4'h0, p, 1'b0, m, w, tbl};
    endfunction

    task automatic l2_write(input logic [ENTRY_W-1:0] e, input string req);
        bit h, b, l3; int ix, cyc; logic [IW-1:0] s; bit placed;
        load(e);
        wr(REG_ADDR, 16'h1ABC);
        s = fold(e[KEY_W-1:0]);
        placed = !m_vld[s] || (m_ent[s][KEY_W-1:0] == e[KEY_W-1:0]);
        issue(ctl(TBL_L2, 1'b1, 3'd0, 4'h0), cyc);
        status(h, b, ix, l3);
        check(req, "write hit", 32'(h), 32'(placed));
        check(req, "write index", ix, placed ? int'(s) : 0);
        check("R3", "write busy cycles", cyc, 1);
        if (placed) begin m_vld[s] = 1'b1; m_ent[s] = e; end
    endtask

    task automatic bank_check(input logic [ENTRY_W-1:0] e, input string req);
        logic [15:0] d;
        for (int w = 0; w < WORDS - 1; w++) begin
            rd(REG_RBANK + 16'(w), d);
            check(req, $sformatf("read word %0d", w), d, e[w*HW +: HW]);
        end
        rd(REG_RBANK + 16'(WORDS - 1), d);
        check("R6", "read word 9", d, {12'h000, e[ENTRY_W-1 -: 4]});
    endtask

    task automatic direct(input int a, input string req);
        bit h, b, l3; int ix, cyc; bit exp;
        wr(REG_ADDR, 16'(a));
        issue(ctl(TBL_L2, 1'b0, SRCH_INDEX, 4'h0), cyc);
        status(h, b, ix, l3);
        exp = (a < DEPTH) && m_vld[a % DEPTH];
        check(req, $sformatf("direct hit @%0d", a), 32'(h), 32'(exp));
        check(req, $sformatf("direct index @%0d", a), ix, exp ? a : 0);
        if (exp) bank_check(m_ent[a], "R12");
    endtask

    task automatic next_check(input int a, input logic [2:0] m, input logic [3:0] p, input string req);
        bit h, b, l3; int ix, cyc, exp_ix; logic [15:0] d;
        exp_ix = -1;
        for (int k = 1; k <= DEPTH && exp_ix < 0; k++) begin
            int i = (a + k) % DEPTH;
            bit ok = m_vld[i];
            if (m == SRCH_NEXT_UC) ok = ok && !m_ent[i][MC_BIT];
            if (m == SRCH_NEXT_MC) ok = ok && m_ent[i][MC_BIT];
            if (m == SRCH_NEXT_UC_PORT) ok = ok && !m_ent[i][MC_BIT] && (m_ent[i][PORT_LO +: 4] == p);
            if (ok) exp_ix = i;
        end
        wr(REG_ADDR, 16'(a));
        issue(ctl(TBL_L2, 1'b0, m, p), cyc);
        status(h, b, ix, l3);
        check(req, $sformatf("next m%0d p%0d from %0d hit", m, p, a), 32'(h), 32'(exp_ix >= 0));
        check(req, $sformatf("next m%0d p%0d from %0d index", m, p, a), ix, exp_ix >= 0 ? exp_ix : 0);
        rd(REG_RBANK, d);
        check("R12", "next read word 0", d, exp_ix >= 0 ? m_ent[exp_ix][15:0] : 16'h0);
    endtask

    task automatic t_reset();
        bit h, b, l3; int ix; logic [15:0] d;
        status(h, b, ix, l3);
        check("R1", "reset hit", 32'(h), 0);
        check("R1", "reset busy", 32'(b), 0);
        check("R1", "reset index", ix, 0);
        rd(REG_ADDR, d);  check("R1", "reset addr", d, 0);
        rd(REG_RBANK, d); check("R1", "reset read word 0", d, 0);
        rd(REG_RBANK + 16'd9, d); check("R1", "reset read word 9", d, 0);
        wr(REG_ADDR, 16'hFFFF);
        rd(REG_ADDR, d);  check("R2", "addr width", d, 16'h1FFF);
        rd(REG_CTRL, d);  check("R2", "control reads zero", d, 0);
    endtask

    task automatic t_empty_scan();
        bit h, b, l3; int ix, cyc;
        wr(REG_ADDR, 16'd5);
        issue(ctl(TBL_L2, 1'b0, SRCH_NEXT, 4'h0), cyc);
        status(h, b, ix, l3);
        check("R9", "empty scan busy cycles", cyc, DEPTH);
        check("R9", "empty scan hit", 32'(h), 0);
    endtask

    task automatic t_ignore_busy();
        bit h, b, l3; int ix, n; logic [15:0] d; logic [ENTRY_W-1:0] x;
        x = mk(48'h0A0B_0C0D_0E0F, 12'h123, 4'h2, 16'h7777);
        load(x);
        wr(REG_ADDR, 16'd9);
        wr(REG_CTRL, ctl(TBL_L2, 1'b0, SRCH_NEXT, 4'h0));
        wr(REG_CTRL, ctl(TBL_L2, 1'b1, 3'd0, 4'h0));
        wr(REG_ADDR, 16'd30);
        n = 0;
        status(h, b, ix, l3);
        check("R3", "busy during scan", 32'(b), 1);
        while (b && n < 1000) begin n++; @(negedge clk); status(h, b, ix, l3); end
        rd(REG_ADDR, d);
        check("R3", "addr write while busy ignored", d, 16'd9);
        direct(int'(fold(x[KEY_W-1:0])), "R3");
    endtask

    task automatic t_key_match(input logic [ENTRY_W-1:0] a);
        bit h, b, l3; int ix, cyc; logic [15:0] d; logic [ENTRY_W-1:0] y;
        load(a);
        wr(REG_ADDR, 16'h003F);
        issue(ctl(TBL_L2, 1'b0, SRCH_KEY, 4'h0), cyc);
        status(h, b, ix, l3);
        check("R7", "key match hit", 32'(h), 1);
        check("R7", "key match index", ix, int'(fold(a[KEY_W-1:0])));
        check("R4", "L2 type flag", 32'(l3), 0);
        bank_check(a, "R7");
        y = a; y[59:48] = y[59:48] ^ 12'h001; y[47:0] = y[47:0] ^ 48'h41;
        load(y);
        issue(ctl(TBL_L2, 1'b0, SRCH_KEY, 4'h0), cyc);
        status(h, b, ix, l3);
        check("R7", "unknown key hit", 32'(h), 32'(m_vld[fold(y[KEY_W-1:0])] &&
              m_ent[fold(y[KEY_W-1:0])][KEY_W-1:0] == y[KEY_W-1:0]));
        check("R4", "miss index zero", ix, 0);
        rd(REG_RBANK, d);
        check("R12", "miss clears read bank", d, 0);
    endtask

    task automatic t_other();
        bit h, b, l3; int ix, cyc; logic [15:0] d; logic [ENTRY_W-1:0] f;
        f = mk(48'h5A5A_1234_9876, 12'h0F0, 4'h1, 16'h4242);
        load(f);
        issue(ctl(3'd1, 1'b1, 3'd0, 4'h0), cyc);
        status(h, b, ix, l3);
        check("R13", "other table hit", 32'(h), 0);
        direct(int'(fold(f[KEY_W-1:0])), "R13");
        issue(ctl(TBL_L2, 1'b0, 3'd6, 4'h0), cyc);
        status(h, b, ix, l3);
        check("R13", "method 6 hit", 32'(h), 0);
        rd(REG_RBANK, d);
        check("R13", "method 6 read bank", d, 0);
        issue(ctl(TBL_L2, 1'b0, 3'd7, 4'h0), cyc);
        status(h, b, ix, l3);
        check("R13", "method 7 hit", 32'(h), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [ENTRY_W-1:0] a, a2, c, bm, dd, e;
        int ha;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_empty_scan();
        t_ignore_busy();

        a = mk(48'h0011_2233_4455, 12'h00A, 4'h3, 16'h1111);
        ha = int'(fold(a[KEY_W-1:0]));
        l2_write(a, "R5");
        direct(ha, "R8");
        t_key_match(a);

        c = a; c[47:0] = c[47:0] ^ 48'h41;        // same fold, different key
        l2_write(c, "R5");
        direct(ha, "R5");
        a2 = a; a2[PORT_LO +: 4] = 4'h9; a2[143:128] = 16'hBEEF;
        l2_write(a2, "R5");
        direct(ha, "R5");
        a2[PORT_LO +: 4] = 4'h3; l2_write(a2, "R5");

        direct(DEPTH, "R8");
        direct((ha + 1) % DEPTH, "R8");

        bm = mk(48'h0100_5E00_00FB, 12'h00A, 4'h5, 16'h2222);
        dd = mk(48'h00AA_BBCC_DD01, 12'h010, 4'h7, 16'h3333);
        e  = mk(48'h0024_6810_1214, 12'h3C1, 4'h3, 16'h4444);
        l2_write(bm, "R5");
        l2_write(dd, "R5");
        l2_write(e, "R5");

        foreach (m_vld[i]) if (m_vld[i]) begin
            next_check(i, SRCH_NEXT, 4'h0, "R9");
            next_check(i, SRCH_NEXT_UC, 4'h0, "R10");
            next_check(i, SRCH_NEXT_MC, 4'h0, "R10");
        end
        next_check(0, SRCH_NEXT, 4'h0, "R9");
        next_check(DEPTH - 1, SRCH_NEXT, 4'h0, "R9");
        next_check(0, SRCH_NEXT_UC_PORT, 4'h3, "R11");
        next_check(ha, SRCH_NEXT_UC_PORT, 4'h3, "R11");
        next_check(0, SRCH_NEXT_UC_PORT, 4'h7, "R11");
        next_check(0, SRCH_NEXT_UC_PORT, 4'h5, "R11");
        next_check(0, SRCH_NEXT_UC_PORT, 4'hC, "R11");

        t_other();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule